// File: doc/BRIEF.md
# Delayed-Execution Pipeline Interlock Controller

This block is the issue control and bypass steering for a seven-stage in-order integer pipeline. The ALU sits one stage after address generation, which shortens load-use stalls. Each cycle the block sees the instruction held in decode: its valid bit, class, two source registers and destination register. It decides whether that instruction may leave decode. It also keeps its own record of the instructions in execution stages E1 to E7: their class, destination and source fields, shifted one stage per clock.

Operands are needed at different stages depending on how they are used. A memory address is needed in E1, ALU operands in E2, and store data in E4. Results become valid at different times by producer class: an ALU result at the end of E2, a load result at the end of E3. So the stall distance is worked out from the producer's current stage, its ready stage and the consumer's use stage, not from one fixed load-use rule. Once the instruction is in its use stage, the block names the execution stage whose pipeline latch supplies each operand, or the register file. Branches and empty slots never wait on the integer interlock.

Top module: `pipe_interlock`

## Requirements
- R1: While reset is active and on the first cycle after it, no instruction is in flight, `stall` is 0 and every forward select is 0.
- R2: An ALU instruction that reads the result of the ALU instruction immediately before it is not stalled. When it reaches E2, its select for that operand is 3 (the producer is then in E3).
- R3: An ALU instruction that reads the destination of the load immediately before it stalls for exactly one cycle.
- R4: A load or store whose address register (operand a) is written by the immediately preceding load stalls for two cycles. If the writer is the immediately preceding ALU instruction, it stalls for one cycle.
- R5: A store whose data register (operand b) is written by the immediately preceding load is not stalled. When the store reaches E4, its data select is 5.
- R6: A forward select holds the stage number (1 to 7) of the youngest in-flight writer of the consumer's register that is older than the consumer. The value 0 means the register file, and it applies once the writer has left E7. The selects are `fwd_agen` for operand a of a load or store in E1, `fwd_alu_a` and `fwd_alu_b` for an ALU in E2, and `fwd_std` for operand b of a store in E4.
- R7: Register 0 is a constant zero. A source of 0 never stalls and never selects a bypass, and a destination of 0 creates no producer.
- R8: Class codes are 0 none, 1 ALU, 2 load, 3 store and 4 branch. A branch, a class 0 slot or a decode slot with `id_valid` low never raises `stall`. Stores and branches write no register.
- R9: While `stall` is high, the decode instruction is not accepted, E1 receives a bubble, and older instructions keep advancing one stage per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_class | input | 3 | Class code of the decode instruction |
| id_src_a | input | REG_W | Source a: address base, or first ALU operand |
| id_src_b | input | REG_W | Source b: second ALU operand, or store data |
| id_dst | input | REG_W | Destination register |
| stall | output | 1 | Hold decode and insert a bubble into E1 |
| fwd_agen | output | SEL_W | Source stage for the address operand in E1 |
| fwd_alu_a | output | SEL_W | Source stage for ALU operand a in E2 |
| fwd_alu_b | output | SEL_W | Source stage for ALU operand b in E2 |
| fwd_std | output | SEL_W | Source stage for store data in E4 |

## Verification
`stall` is combinational from the decode inputs and the in-flight record, so it is due in the same cycle as the stimulus. The bench drives each instruction just after the falling edge and samples `stall` 1 ns later, before the next rising edge. A forward select is due N rising edges after its consumer is accepted, where N is the consumer's use stage: 1 for the address, 2 for ALU operands and 4 for store data. Each task counts those edges from the accept cycle and samples at the matching falling-edge offset, using producer positions worked out by hand from the class timings.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef logic [3:0] stg_t;

  typedef enum logic [2:0] {
    CL_NONE   = 3'd0,
    CL_ALU    = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4
  } iclass_e;

  // stage in which each kind of operand is consumed
  localparam stg_t AGEN_AT = 4'd1;
  localparam stg_t ALU_AT  = 4'd2;
  localparam stg_t STD_AT  = 4'd4;
  // stage at whose end each producer's result becomes valid
  localparam stg_t ALU_RDY  = 4'd2;
  localparam stg_t LOAD_RDY = 4'd3;

  function automatic stg_t use_a(input logic [2:0] c);
    case (c)
      CL_ALU:             return ALU_AT;
      CL_LOAD, CL_STORE:  return AGEN_AT;
      default:            return 4'd0;
    endcase
  endfunction

  function automatic stg_t use_b(input logic [2:0] c);
    case (c)
      CL_ALU:   return ALU_AT;
      CL_STORE: return STD_AT;
      default:  return 4'd0;
    endcase
  endfunction

  function automatic stg_t ready_at(input logic [2:0] c);
    case (c)
      CL_ALU:  return ALU_RDY;
      CL_LOAD: return LOAD_RDY;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic writes_reg(input logic [2:0] c);
    return (c == CL_ALU) || (c == CL_LOAD);
  endfunction

  // producer now in prod, consumer issuing now uses the value u cycles later
  function automatic logic too_early(input stg_t prod, input stg_t u, input stg_t rdy);
    return (5'(prod) + 5'(u)) <= 5'(rdy);
  endfunction

endpackage

// File: rtl/ilk_track.sv
module ilk_track
  import ilk_pkg::*;
#(
  parameter int STAGES = 7,
  parameter int REG_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue,
  input  logic [2:0]                    in_cls,
  input  logic [REG_W-1:0]              in_a,
  input  logic [REG_W-1:0]              in_b,
  input  logic [REG_W-1:0]              in_dst,
  output logic [STAGES-1:0]             st_vld,
  output logic [STAGES-1:0]             st_wr,
  output logic [STAGES-1:0][2:0]        st_cls,
  output logic [STAGES-1:0][REG_W-1:0]  st_a,
  output logic [STAGES-1:0][REG_W-1:0]  st_b,
  output logic [STAGES-1:0][REG_W-1:0]  st_dst
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_vld[i] <= 1'b0;
          st_cls[i] <= CL_NONE;
          st_a[i]   <= '0;
          st_b[i]   <= '0;
          st_dst[i] <= '0;
        end else if (issue) begin
          st_vld[i] <= 1'b1;
          st_cls[i] <= in_cls;
          st_a[i]   <= in_a;
          st_b[i]   <= in_b;
          st_dst[i] <= in_dst;
        end else begin
          st_vld[i] <= 1'b0;
          st_cls[i] <= CL_NONE;
          st_a[i]   <= '0;
          st_b[i]   <= '0;
          st_dst[i] <= '0;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_vld[i] <= 1'b0;
          st_cls[i] <= CL_NONE;
          st_a[i]   <= '0;
          st_b[i]   <= '0;
          st_dst[i] <= '0;
        end else begin
          st_vld[i] <= st_vld[i-1];
          st_cls[i] <= st_cls[i-1];
          st_a[i]   <= st_a[i-1];
          st_b[i]   <= st_b[i-1];
          st_dst[i] <= st_dst[i-1];
        end
      end
    end
    assign st_wr[i] = st_vld[i] && writes_reg(st_cls[i]) && (st_dst[i] != '0);
  end

  // R9
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld[0] |=> st_vld[1]);

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
  import ilk_pkg::*;
#(
  parameter int STAGES = 7,
  parameter int REG_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [REG_W-1:0]              src,
  input  stg_t                          use_at,
  input  logic [STAGES-1:0]             st_wr,
  input  logic [STAGES-1:0][2:0]        st_cls,
  input  logic [STAGES-1:0][REG_W-1:0]  st_dst,
  output logic                          need_stall
);

  logic found;
  stg_t hit_stage;
  stg_t hit_rdy;

  // youngest in-flight writer of src: lowest stage number wins
  always_comb begin
    found     = 1'b0;
    hit_stage = '0;
    hit_rdy   = '0;
    if (src != '0) begin
      for (int i = 0; i < STAGES; i++) begin
        if (!found && st_wr[i] && (st_dst[i] == src)) begin
          found     = 1'b1;
          hit_stage = stg_t'(i + 1);
          hit_rdy   = ready_at(st_cls[i]);
        end
      end
    end
  end

  assign need_stall = (use_at != '0) && found && too_early(hit_stage, use_at, hit_rdy);

  // R7
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> !need_stall);

endmodule

// File: rtl/ilk_fwd.sv
module ilk_fwd
  import ilk_pkg::*;
#(
  parameter int STAGES  = 7,
  parameter int REG_W   = 4,
  parameter int CONS_AT = 2,
  localparam int SEL_W  = $clog2(STAGES + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic [REG_W-1:0]              src,
  input  logic [STAGES-1:0]             st_wr,
  input  logic [STAGES-1:0][2:0]        st_cls,
  input  logic [STAGES-1:0][REG_W-1:0]  st_dst,
  output logic [SEL_W-1:0]              sel
);

  logic found;

  // only stages older than the consumer (index CONS_AT is stage CONS_AT+1)
  always_comb begin
    found = 1'b0;
    sel   = '0;
    if (en && (src != '0)) begin
      for (int i = CONS_AT; i < STAGES; i++) begin
        if (!found && st_wr[i] && (st_dst[i] == src)) begin
          found = 1'b1;
          sel   = SEL_W'(i + 1);
        end
      end
    end
  end

  // R6: a bypassed value must already be computed
  fwd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> (ready_at(st_cls[int'(sel) - 1]) < stg_t'(sel)));

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import ilk_pkg::*;
#(
  parameter int  NUM_REGS = 16,
  parameter int  STAGES   = 7,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int SEL_W    = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [2:0]        id_class,
  input  logic [REG_W-1:0]  id_src_a,
  input  logic [REG_W-1:0]  id_src_b,
  input  logic [REG_W-1:0]  id_dst,
  output logic              stall,
  output logic [SEL_W-1:0]  fwd_agen,
  output logic [SEL_W-1:0]  fwd_alu_a,
  output logic [SEL_W-1:0]  fwd_alu_b,
  output logic [SEL_W-1:0]  fwd_std
);

  localparam int AG_IX  = int'(AGEN_AT) - 1;
  localparam int ALU_IX = int'(ALU_AT) - 1;
  localparam int STD_IX = int'(STD_AT) - 1;
  localparam int NFWD   = 4;
  localparam int FWD_AT [NFWD] = '{int'(AGEN_AT), int'(ALU_AT), int'(ALU_AT), int'(STD_AT)};

  logic [STAGES-1:0]            st_vld;
  logic [STAGES-1:0]            st_wr;
  logic [STAGES-1:0][2:0]       st_cls;
  logic [STAGES-1:0][REG_W-1:0] st_a;
  logic [STAGES-1:0][REG_W-1:0] st_b;
  logic [STAGES-1:0][REG_W-1:0] st_dst;

  // named internal events
  logic                   accept;
  logic                   e1_vld;
  logic [REG_W-1:0]       e1_dst;
  logic [1:0]             op_stall;
  logic [1:0][REG_W-1:0]  op_src;
  logic [1:0][3:0]        op_use;

  assign op_src[0] = id_src_a;
  assign op_src[1] = id_src_b;
  assign op_use[0] = use_a(id_class);
  assign op_use[1] = use_b(id_class);

  for (genvar k = 0; k < 2; k++) begin : g_op
    ilk_hazard #(.STAGES(STAGES), .REG_W(REG_W)) u_haz (
      .clk        (clk),
      .rst_n      (rst_n),
      .src        (op_src[k]),
      .use_at     (op_use[k]),
      .st_wr      (st_wr),
      .st_cls     (st_cls),
      .st_dst     (st_dst),
      .need_stall (op_stall[k])
    );
  end

  assign stall  = id_valid && (op_stall != 2'b00);
  assign accept = id_valid && !stall;

  ilk_track #(.STAGES(STAGES), .REG_W(REG_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (accept),
    .in_cls (id_class),
    .in_a   (id_src_a),
    .in_b   (id_src_b),
    .in_dst (id_dst),
    .st_vld (st_vld),
    .st_wr  (st_wr),
    .st_cls (st_cls),
    .st_a   (st_a),
    .st_b   (st_b),
    .st_dst (st_dst)
  );

  assign e1_vld = st_vld[0];
  assign e1_dst = st_dst[0];

  logic [NFWD-1:0]             fw_en;
  logic [NFWD-1:0][REG_W-1:0]  fw_src;
  logic [NFWD-1:0][SEL_W-1:0]  fw_sel;

  assign fw_en[0]  = st_vld[AG_IX]  && (use_a(st_cls[AG_IX])  == AGEN_AT);
  assign fw_src[0] = st_a[AG_IX];
  assign fw_en[1]  = st_vld[ALU_IX] && (use_a(st_cls[ALU_IX]) == ALU_AT);
  assign fw_src[1] = st_a[ALU_IX];
  assign fw_en[2]  = st_vld[ALU_IX] && (use_b(st_cls[ALU_IX]) == ALU_AT);
  assign fw_src[2] = st_b[ALU_IX];
  assign fw_en[3]  = st_vld[STD_IX] && (use_b(st_cls[STD_IX]) == STD_AT);
  assign fw_src[3] = st_b[STD_IX];

  for (genvar f = 0; f < NFWD; f++) begin : g_fwd
    ilk_fwd #(.STAGES(STAGES), .REG_W(REG_W), .CONS_AT(FWD_AT[f])) u_fwd (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (fw_en[f]),
      .src    (fw_src[f]),
      .st_wr  (st_wr),
      .st_cls (st_cls),
      .st_dst (st_dst),
      .sel    (fw_sel[f])
    );
  end

  assign fwd_agen  = fw_sel[0];
  assign fwd_alu_a = fw_sel[1];
  assign fwd_alu_b = fw_sel[2];
  assign fwd_std   = fw_sel[3];

  // R9
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !e1_vld);

  // R9
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !stall) |=> (e1_vld && (e1_dst == $past(id_dst))));

  // R8
  no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid || (id_class == CL_BRANCH) || (id_class == CL_NONE)) |-> !stall);

endmodule

// File: tb/pipe_interlock_tb.sv
module pipe_interlock_tb;

  localparam logic [2:0] C_NONE = 3'd0, C_ALU = 3'd1, C_LOAD = 3'd2,
                         C_STORE = 3'd3, C_BR = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       id_valid = 1'b0;
  logic [2:0] id_class = 3'd0;
  logic [3:0] id_src_a = 4'd0, id_src_b = 4'd0, id_dst = 4'd0;
  logic       stall;
  logic [2:0] fwd_agen, fwd_alu_a, fwd_alu_b, fwd_std;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pipe_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_class(id_class),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
    .stall(stall), .fwd_agen(fwd_agen), .fwd_alu_a(fwd_alu_a),
    .fwd_alu_b(fwd_alu_b), .fwd_std(fwd_std)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c,
                       input logic [3:0] a, input logic [3:0] b, input logic [3:0] d);
    id_valid = v; id_class = c; id_src_a = a; id_src_b = b; id_dst = d;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, C_NONE, 4'd0, 4'd0, 4'd0);
  endtask

  // one rising edge, then resume 0.5 ns after the following falling edge
  task automatic tick();
    @(negedge clk);
    #0.5;
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 9; i++) tick();
  endtask

  task automatic t_reset();
    idle();
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "fwd_agen in reset", fwd_agen, 0);
    chk("R1", "fwd_alu_a in reset", fwd_alu_a, 0);
    @(negedge clk); rst_n = 1'b1; #0.5;
    idle();
    chk("R1", "stall after reset", stall, 0);
    chk("R1", "fwd_alu_b after reset", fwd_alu_b, 0);
    chk("R1", "fwd_std after reset", fwd_std, 0);
  endtask

  task automatic t_alu_pair();
    drive(1, C_ALU, 4'd2, 4'd3, 4'd1);
    chk("R2", "producer stall", stall, 0);
    tick(); drive(1, C_ALU, 4'd1, 4'd5, 4'd4);
    chk("R2", "ALU after ALU stall", stall, 0);
    tick(); idle();
    chk("R6", "ALU consumer in E1 agen", fwd_agen, 0);
    tick();
    chk("R2", "ALU bypass a from E3", fwd_alu_a, 3);
    chk("R6", "unrelated b from regfile", fwd_alu_b, 0);
    drain();
  endtask

  task automatic t_load_alu();
    drive(1, C_LOAD, 4'd2, 4'd0, 4'd6);
    chk("R3", "load issue stall", stall, 0);
    tick(); drive(1, C_ALU, 4'd7, 4'd6, 4'd8);
    chk("R3", "load-use first cycle", stall, 1);
    tick();
    chk("R3", "load-use second cycle", stall, 0);
    tick(); idle();
    tick();
    chk("R3", "ALU b from load in E4", fwd_alu_b, 4);
    chk("R9", "ALU a from regfile", fwd_alu_a, 0);
    drain();
  endtask

  task automatic t_load_addr();
    drive(1, C_LOAD, 4'd2, 4'd0, 4'd8);
    tick(); drive(1, C_LOAD, 4'd8, 4'd0, 4'd9);
    chk("R4", "load-address cycle 1", stall, 1);
    tick();
    chk("R4", "load-address cycle 2", stall, 1);
    tick();
    chk("R4", "load-address cycle 3", stall, 0);
    tick(); idle();
    chk("R4", "address from load in E4", fwd_agen, 4);
    tick();
    chk("R6", "load in E2 has no ALU operand", fwd_alu_a, 0);
    drain();
  endtask

  task automatic t_alu_addr_youngest();
    drive(1, C_LOAD, 4'd2, 4'd0, 4'd3);
    tick(); drive(1, C_ALU, 4'd1, 4'd1, 4'd3);
    tick(); drive(1, C_STORE, 4'd3, 4'd0, 4'd0);
    chk("R4", "ALU-address stall", stall, 1);
    tick();
    chk("R4", "ALU-address released", stall, 0);
    tick(); idle();
    chk("R6", "youngest writer E3 over E4", fwd_agen, 3);
    tick(); tick(); tick();
    chk("R7", "store data r0 not bypassed", fwd_std, 0);
    drain();
  endtask

  task automatic t_load_std();
    drive(1, C_LOAD, 4'd2, 4'd0, 4'd10);
    tick(); drive(1, C_STORE, 4'd2, 4'd10, 4'd0);
    chk("R5", "store data after load", stall, 0);
    tick(); idle();
    chk("R5", "store address from regfile", fwd_agen, 0);
    tick(); tick(); tick();
    chk("R5", "store data from E5", fwd_std, 5);
    drain();
  endtask

  task automatic t_zero();
    drive(1, C_ALU, 4'd1, 4'd1, 4'd0);
    tick(); drive(1, C_LOAD, 4'd0, 4'd0, 4'd5);
    chk("R7", "r0 address no stall", stall, 0);
    tick(); idle();
    chk("R7", "r0 address no bypass", fwd_agen, 0);
    drain();
  endtask

  task automatic t_branch();
    drive(1, C_LOAD, 4'd2, 4'd0, 4'd5);
    tick(); drive(1, C_BR, 4'd5, 4'd5, 4'd0);
    chk("R8", "branch never stalls", stall, 0);
    tick(); drive(0, C_LOAD, 4'd5, 4'd0, 4'd7);
    chk("R8", "invalid slot no stall", stall, 0);
    drive(1, C_LOAD, 4'd5, 4'd0, 4'd7);
    chk("R4", "same slot valid stalls", stall, 1);
    drain();
    drive(1, C_STORE, 4'd2, 4'd2, 4'd6);
    tick(); drive(1, C_LOAD, 4'd6, 4'd0, 4'd9);
    chk("R8", "store dst not a producer", stall, 0);
    tick(); idle();
    chk("R8", "store dst not bypassed", fwd_agen, 0);
    drain();
  endtask

  task automatic t_writeback();
    drive(1, C_ALU, 4'd1, 4'd1, 4'd11);
    tick(); idle();
    for (int i = 0; i < 4; i++) tick();
    drive(1, C_ALU, 4'd11, 4'd0, 4'd12);
    chk("R6", "late consumer stall", stall, 0);
    tick(); drive(1, C_ALU, 4'd11, 4'd0, 4'd13);
    tick(); idle();
    chk("R6", "bypass from E7", fwd_alu_a, 7);
    tick();
    chk("R6", "regfile after E7", fwd_alu_a, 0);
    drain();
  endtask

  initial begin
    #0.5;
    @(negedge clk); #0.5;
    t_reset();
    t_alu_pair();
    t_load_alu();
    t_load_addr();
    t_alu_addr_youngest();
    t_load_std();
    t_zero();
    t_branch();
    t_writeback();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule